// File: doc/BRIEF.md
# I2C Master Slave-Monitor Retry Engine

This block runs the master-side polling loop that waits for a target device on an I2C bus to answer. Monitoring is armed when master mode and the monitor enable are both set. A write to the address register then starts a sequence of addressing attempts. Each attempt is a START, the address with the write direction bit, a check of the acknowledge bit and a STOP, with no data bytes. A lower bit-level engine carries out each attempt and is outside this block. The retry engine asks for an attempt with a one-cycle request and presents the address bytes. It then waits for the engine's done strobe, which comes with the acknowledge result.

When an attempt is not acknowledged, no NACK event is raised. The engine counts a programmable number of SCL periods on an SCL tick input and then tries again. The first acknowledge ends the sequence with a one-cycle slave-ready event. Clearing either enable ends the sequence cleanly. A new address write while a sequence is running restarts it with the new address.

Top module: `i2c_slvmon_engine`

## Requirements
- R1: An address write (`addr_wr`) starts a sequence only while `cfg_master` and `cfg_mon_en` are both 1. Otherwise the address is only stored and no attempt is requested.
- R2: An arming write that is sampled at a clock edge in idle makes `att_start` high for exactly the following cycle.
- R3: When `cfg_addr7` is 1 at the write, the attempt uses 7-bit form: `att_byte0` = {addr[6:0], 0}, `att_byte1` = 0, `att_two` = 0.
- R4: When `cfg_addr7` is 0 at the write, the attempt uses 10-bit form: `att_byte0` = {5'b11110, addr[9:8], 0}, `att_byte1` = addr[7:0], `att_two` = 1.
- R5: After a done strobe with `att_ack` = 0, the engine waits for p+1 `scl_tick` pulses, where p is `cfg_pause` sampled with the done strobe. A tick in the done cycle does not count. The next `att_start` appears in the cycle after the edge that samples the last counted tick.
- R6: With p = 0, the retry is requested right after the first SCL tick that follows the failed attempt.
- R7: A done strobe with `att_ack` = 1 makes `slv_rdy` high for exactly the next cycle and ends the sequence, with no further attempts.
- R8: A not-acknowledged attempt never raises `slv_rdy`. It only leads to the pause and then the next attempt.
- R9: If either enable is low when an attempt's done strobe is sampled, the engine returns to idle with no event. If either enable is low during a pause, it returns to idle at once without a further attempt.
- R10: An arming write during a pause requests a new attempt with the new address in the next cycle. An arming write while an attempt is in flight discards that attempt's result, and the new address is tried in the cycle after its done strobe.
- R11: At most one attempt is outstanding. The attempt fields stay stable from `att_start` until the done strobe.
- R12: After reset the engine is idle with `att_start`, `slv_rdy`, `att_two`, `att_byte0` and `att_byte1` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_master | input | 1 | Master mode selected |
| cfg_mon_en | input | 1 | Monitor enable |
| cfg_addr7 | input | 1 | 1 selects 7-bit, 0 selects 10-bit addressing |
| cfg_pause | input | 4 | Inter-attempt pause, SCL periods minus one |
| addr_wr | input | 1 | Address register write strobe |
| addr_wdata | input | 10 | Address written |
| scl_tick | input | 1 | One-cycle pulse per SCL period |
| att_start | output | 1 | Request one addressing attempt |
| att_byte0 | output | 8 | First address byte of the attempt |
| att_byte1 | output | 8 | Second address byte (10-bit form only) |
| att_two | output | 1 | Attempt sends two address bytes |
| att_done | input | 1 | Attempt finished |
| att_ack | input | 1 | Result with done: 1 acknowledged |
| slv_rdy | output | 1 | Monitored device answered, one-cycle event |

## Verification
Assertions check the following on every cycle: the single-cycle request and ready pulses, that a request follows an arming write, that idle is quiet and a disabled pause issues nothing, that a NACK stays silent, and that ready traces back to an acknowledged done strobe. They also check that the attempt fields are stable and that the pause count holds without ticks. The exact retry spacing in SCL ticks, the address byte layouts, and the restart cases (a write during a pause, or during an attempt whose result must be discarded) can only be shown by the bench. It runs scenarios against a behavioural model compared each cycle.

// File: rtl/slvmon_pkg.sv
// Package: shared state encoding for the slave-monitor retry engine.
// Assumes: imported by the sequencer; no other dependencies.
package slvmon_pkg;
    typedef enum logic [1:0] {
        MON_IDLE  = 2'd0,
        MON_ISSUE = 2'd1,
        MON_WAIT  = 2'd2,
        MON_PAUSE = 2'd3
    } mon_state_e;
endpackage

// File: rtl/slvmon_addr_fmt.sv
// Module: builds the address bytes of one write-direction addressing attempt.
// Assumes: ADDR_W is 10 (8 low bits plus HI_W high bits for extended form).
module slvmon_addr_fmt #(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ten,
    output logic [7:0]        byte0,
    output logic [7:0]        byte1,
    output logic              two
);
    localparam int HI_W = ADDR_W - 8;
    localparam logic [4:0] EXT_PREFIX = 5'b11110;

    // Select one-byte or two-byte layout; direction bit is always write (0).
    always_comb begin
        if (ten) begin
            byte0 = {EXT_PREFIX, addr[ADDR_W-1 -: HI_W], 1'b0};
            byte1 = addr[7:0];
            two   = 1'b1;
        end else begin
            byte0 = {addr[6:0], 1'b0};
            byte1 = 8'd0;
            two   = 1'b0;
        end
    end
endmodule

// File: rtl/slvmon_pause_timer.sv
// Module: counts SCL ticks for the gap between attempts.
// Assumes: load is given once when a pause begins; expire pulses on the tick
// that completes load_val+1 counted ticks while run is high.
module slvmon_pause_timer #(
    parameter int PAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PAUSE_W-1:0] load_val,
    input  logic               run,
    input  logic               tick,
    output logic               expire
);
    logic [PAUSE_W-1:0] cnt_q;

    assign expire = run && tick && (cnt_q == '0);

    // Remaining-tick counter: load, then step down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (load)                    cnt_q <= load_val;
        else if (run && tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // R5: without a tick the remaining count must not move.
    p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/slvmon_seq_ctrl.sv
// Module: sequencer for the monitor loop (idle, issue, wait result, pause).
// Assumes: the bit-level engine accepts att_start only while idle itself and
// answers every request with exactly one att_done pulse carrying att_ack.
module slvmon_seq_ctrl
    import slvmon_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int PAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_master,
    input  logic               cfg_mon_en,
    input  logic               cfg_addr7,
    input  logic [PAUSE_W-1:0] cfg_pause,
    input  logic               addr_wr,
    input  logic [ADDR_W-1:0]  addr_wdata,
    input  logic               att_done,
    input  logic               att_ack,
    input  logic               pause_expire,
    output logic               pause_load,
    output logic [PAUSE_W-1:0] pause_val,
    output logic               pause_run,
    output logic               att_start,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic               cur_ten,
    output logic               slv_rdy
);
    mon_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
    logic              pend_ten_q, pend_ten_d;
    logic              restart_q, restart_eff;
    logic              mon_en, wr_go, rdy_d;

    assign mon_en      = cfg_master && cfg_mon_en;
    assign wr_go       = addr_wr && mon_en;
    assign restart_eff = restart_q || wr_go;
    assign pend_addr_d = addr_wr ? addr_wdata : pend_addr_q;
    assign pend_ten_d  = addr_wr ? !cfg_addr7 : pend_ten_q;

    assign att_start  = (state_q == MON_ISSUE);
    assign pause_run  = (state_q == MON_PAUSE);
    assign pause_load = (state_q == MON_WAIT) && (state_d == MON_PAUSE);
    assign pause_val  = cfg_pause;

    // Next-state decision for the retry loop.
    always_comb begin
        state_d = state_q;
        rdy_d   = 1'b0;
        unique case (state_q)
            MON_IDLE:  if (wr_go) state_d = MON_ISSUE;
            MON_ISSUE: state_d = MON_WAIT;
            MON_WAIT: begin
                if (att_done) begin
                    if (!mon_en)          state_d = MON_IDLE;
                    else if (restart_eff) state_d = MON_ISSUE;
                    else if (att_ack) begin
                        state_d = MON_IDLE;
                        rdy_d   = 1'b1;
                    end else              state_d = MON_PAUSE;
                end
            end
            MON_PAUSE: begin
                if (!mon_en)           state_d = MON_IDLE;
                else if (wr_go)        state_d = MON_ISSUE;
                else if (pause_expire) state_d = MON_ISSUE;
            end
            default: state_d = MON_IDLE;
        endcase
    end

    // State, ready pulse and restart flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= MON_IDLE;
            slv_rdy   <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            state_q <= state_d;
            slv_rdy <= rdy_d;
            if (state_q == MON_WAIT && att_done)
                restart_q <= 1'b0;
            else if ((state_q == MON_ISSUE || state_q == MON_WAIT) && wr_go)
                restart_q <= 1'b1;
            else if (state_q == MON_IDLE || state_q == MON_PAUSE)
                restart_q <= 1'b0;
        end
    end

    // Address holding: pending copy tracks writes, attempt copy loads on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_addr_q <= '0;
            pend_ten_q  <= 1'b0;
            cur_addr    <= '0;
            cur_ten     <= 1'b0;
        end else begin
            pend_addr_q <= pend_addr_d;
            pend_ten_q  <= pend_ten_d;
            if (state_d == MON_ISSUE) begin
                cur_addr <= pend_addr_d;
                cur_ten  <= pend_ten_d;
            end
        end
    end

    // R2: an attempt request lasts a single cycle.
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        att_start |=> !att_start);
    // R1: an idle engine without an arming write requests nothing.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MON_IDLE && !(addr_wr && cfg_master && cfg_mon_en)) |=> !att_start);
    // R2: an arming write in idle is followed by a request.
    p_arm_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MON_IDLE && addr_wr && cfg_master && cfg_mon_en) |=> att_start);
    // R7: ready is one cycle and always follows an acknowledged done strobe.
    p_rdy_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slv_rdy |=> !slv_rdy);
    p_rdy_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slv_rdy |-> $past(att_done && att_ack));
    // R8: a NACK result never produces ready.
    p_nack_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MON_WAIT && att_done && !att_ack) |=> !slv_rdy);
    // R9: a pause with monitoring disabled issues no attempt.
    p_pause_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MON_PAUSE && !(cfg_master && cfg_mon_en)) |=> !att_start);
    // R11: attempt fields do not move while a result is awaited.
    p_fields_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MON_WAIT) |-> ($stable(cur_addr) && $stable(cur_ten)));
endmodule

// File: rtl/i2c_slvmon_engine.sv
// Module: top of the slave-monitor retry engine; joins sequencer, pause
// timer and address formatter.
// Assumes: scl_tick is a one-cycle pulse per SCL period in the clk domain;
// all inputs are synchronous to clk.
module i2c_slvmon_engine #(
    parameter int ADDR_W  = 10,
    parameter int PAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_master,
    input  logic               cfg_mon_en,
    input  logic               cfg_addr7,
    input  logic [PAUSE_W-1:0] cfg_pause,
    input  logic               addr_wr,
    input  logic [ADDR_W-1:0]  addr_wdata,
    input  logic               scl_tick,
    output logic               att_start,
    output logic [7:0]         att_byte0,
    output logic [7:0]         att_byte1,
    output logic               att_two,
    input  logic               att_done,
    input  logic               att_ack,
    output logic               slv_rdy
);
    logic               pause_load, pause_run, pause_expire;
    logic [PAUSE_W-1:0] pause_val;
    logic [ADDR_W-1:0]  cur_addr;
    logic               cur_ten;

    slvmon_seq_ctrl #(.ADDR_W(ADDR_W), .PAUSE_W(PAUSE_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_master(cfg_master), .cfg_mon_en(cfg_mon_en),
        .cfg_addr7(cfg_addr7), .cfg_pause(cfg_pause),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .att_done(att_done), .att_ack(att_ack),
        .pause_expire(pause_expire), .pause_load(pause_load),
        .pause_val(pause_val), .pause_run(pause_run),
        .att_start(att_start), .cur_addr(cur_addr), .cur_ten(cur_ten),
        .slv_rdy(slv_rdy)
    );

    slvmon_pause_timer #(.PAUSE_W(PAUSE_W)) u_pause (
        .clk(clk), .rst_n(rst_n),
        .load(pause_load), .load_val(pause_val),
        .run(pause_run), .tick(scl_tick), .expire(pause_expire)
    );

    slvmon_addr_fmt #(.ADDR_W(ADDR_W)) u_fmt (
        .addr(cur_addr), .ten(cur_ten),
        .byte0(att_byte0), .byte1(att_byte1), .two(att_two)
    );
endmodule

// File: tb/i2c_slvmon_engine_bench.sv
module i2c_slvmon_engine_bench;
    localparam int RESP_LAT = 3;
    localparam int TICK_DIV = 4;

    logic clk = 0, rst_n = 0;
    logic cfg_master = 0, cfg_mon_en = 0, cfg_addr7 = 1;
    logic [3:0] cfg_pause = 0;
    logic addr_wr = 0;
    logic [9:0] addr_wdata = 0;
    logic scl_tick = 0, att_done = 0, att_ack = 0;
    logic att_start, att_two, slv_rdy;
    logic [7:0] att_byte0, att_byte1;

    always #5 clk = ~clk;

    i2c_slvmon_engine u_i2c_slvmon_engine (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_mon_en(cfg_mon_en),
        .cfg_addr7(cfg_addr7), .cfg_pause(cfg_pause), .addr_wr(addr_wr),
        .addr_wdata(addr_wdata), .scl_tick(scl_tick), .att_start(att_start),
        .att_byte0(att_byte0), .att_byte1(att_byte1), .att_two(att_two),
        .att_done(att_done), .att_ack(att_ack), .slv_rdy(slv_rdy));

    int tests = 0, fails = 0, cyc = 0;
    int start_cnt = 0, rdy_cnt = 0, last_start_cyc = 0, last_gap = 0;
    logic [7:0] last_b0 = 0, last_b1 = 0;
    logic last_two = 0;
    bit finished = 0;
    bit ack_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 request, 2 awaiting, 3 pausing.
    int m_phase = 0, m_rem = 0;
    bit m_rest = 0, m_rdy = 0, m_pt = 0, m_ct = 0, m_en, m_go;
    logic [9:0] m_pa = 0, m_ca = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_phase = 0; m_rem = 0; m_rest = 0; m_rdy = 0;
            m_pa = 0; m_pt = 0; m_ca = 0; m_ct = 0;
        end else begin
            m_en = cfg_master && cfg_mon_en;
            m_go = addr_wr && m_en;
            m_rdy = 0;
            if (addr_wr) begin m_pa = addr_wdata; m_pt = !cfg_addr7; end
            case (m_phase)
                0: if (m_go) begin m_phase = 1; m_ca = m_pa; m_ct = m_pt; end
                1: begin m_phase = 2; if (m_go) m_rest = 1; end
                2: begin
                    if (m_go) m_rest = 1;
                    if (att_done) begin
                        if (!m_en) m_phase = 0;
                        else if (m_rest) begin m_phase = 1; m_ca = m_pa; m_ct = m_pt; end
                        else if (att_ack) begin m_phase = 0; m_rdy = 1; end
                        else begin m_phase = 3; m_rem = int'(cfg_pause); end
                        m_rest = 0;
                    end
                end
                default: begin
                    if (!m_en) m_phase = 0;
                    else if (m_go) begin m_phase = 1; m_ca = m_pa; m_ct = m_pt; end
                    else if (scl_tick) begin
                        if (m_rem == 0) begin m_phase = 1; m_ca = m_pa; m_ct = m_pt; end
                        else m_rem--;
                    end
                end
            endcase
        end
    end

    // Expected bytes per R3 (7-bit) and R4 (10-bit).
    function automatic logic [16:0] exp_fields(input logic [9:0] a, input bit ten);
        if (ten) return {1'b1, 5'b11110, a[9:8], 1'b0, a[7:0]};
        return {1'b0, a[6:0], 1'b0, 8'd0};
    endfunction

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        logic [16:0] ef;
        if (rst_n && !finished) begin
            ef = exp_fields(m_ca, m_ct);
            chk(att_start === (m_phase == 1), "R5 request timing", int'(att_start), int'(m_phase == 1));
            chk(slv_rdy === m_rdy, "R7 ready timing", int'(slv_rdy), int'(m_rdy));
            if (att_start === 1'b1) begin
                chk({att_two, att_byte0, att_byte1} === ef, "R3 attempt fields",
                    int'({att_two, att_byte0, att_byte1}), int'(ef));
                start_cnt++;
                last_gap = cyc - last_start_cyc;
                last_start_cyc = cyc;
                last_b0 = att_byte0; last_b1 = att_byte1; last_two = att_two;
            end
            if (slv_rdy === 1'b1) rdy_cnt++;
        end
    end

    // Bit-level engine stand-in and SCL tick source.
    int resp_wait = 0, tick_div = 0;
    always @(negedge clk) begin
        att_done = 0; att_ack = 0;
        if (resp_wait == 1) begin
            att_done = 1;
            att_ack = (ack_q.size() > 0) ? ack_q.pop_front() : 1'b0;
            resp_wait = 0;
        end else if (resp_wait > 1) resp_wait--;
        if (att_start === 1'b1) resp_wait = RESP_LAT;
        tick_div = (tick_div + 1) % TICK_DIV;
        scl_tick = (tick_div == 0);
    end

    task automatic write_addr(input logic [9:0] a, input logic a7);
        @(negedge clk);
        addr_wdata = a; cfg_addr7 = a7; addr_wr = 1;
        @(negedge clk);
        addr_wr = 0;
    endtask

    task automatic wait_for(input int n_start, input int n_rdy, input int maxc);
        for (int i = 0; i < maxc; i++) begin
            if (start_cnt >= n_start && rdy_cnt >= n_rdy) break;
            @(negedge clk);
        end
    endtask

    task automatic settle();
        cfg_mon_en = 0;
        repeat (20) @(negedge clk);
        ack_q.delete();
        start_cnt = 0; rdy_cnt = 0;
    endtask

    task automatic summary();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 150000 && !finished) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(att_start === 0 && slv_rdy === 0, "R12 reset pulses", int'({att_start, slv_rdy}), 0);
        chk({att_two, att_byte0, att_byte1} === 17'd0, "R12 reset fields",
            int'({att_two, att_byte0, att_byte1}), 0);
        rst_n = 1;
        @(negedge clk);

        // R1: write with monitor disabled, then with slave mode
        cfg_master = 1; cfg_mon_en = 0;
        write_addr(10'h055, 1);
        repeat (30) @(negedge clk);
        chk(start_cnt == 0, "R1 monitor off", start_cnt, 0);
        cfg_master = 0; cfg_mon_en = 1;
        write_addr(10'h055, 1);
        repeat (30) @(negedge clk);
        chk(start_cnt == 0, "R1 slave mode", start_cnt, 0);
        settle();

        // R2 R3 R6 R8 R7: 7-bit, pause 0, two NACKs then ACK
        cfg_master = 1; cfg_mon_en = 1; cfg_pause = 0;
        ack_q = '{0, 0, 1};
        write_addr(10'h02A, 1);
        chk(start_cnt == 1 || att_start === 1'b1, "R2 request after write", start_cnt, 1);
        wait_for(3, 1, 400);
        chk(start_cnt == 3, "R8 retries after NACK", start_cnt, 3);
        chk(rdy_cnt == 1, "R7 one ready event", rdy_cnt, 1);
        chk(last_b0 == 8'h54 && last_two == 0 && last_b1 == 0, "R3 7-bit byte", int'(last_b0), 'h54);
        chk(last_gap <= RESP_LAT + TICK_DIV + 2, "R6 zero pause gap", last_gap, RESP_LAT + TICK_DIV + 2);
        repeat (60) @(negedge clk);
        chk(start_cnt == 3, "R7 no attempt after ack", start_cnt, 3);
        settle();

        // R4 R5: 10-bit, pause 3
        cfg_mon_en = 1; cfg_pause = 3;
        ack_q = '{0, 1};
        write_addr(10'h2C5, 0);
        wait_for(2, 1, 400);
        chk(start_cnt == 2 && rdy_cnt == 1, "R5 one retry then ready", start_cnt, 2);
        chk(last_b0 == 8'hF4 && last_b1 == 8'hC5 && last_two == 1, "R4 10-bit bytes",
            int'({last_b0, last_b1}), 'hF4C5);
        chk(last_gap >= RESP_LAT + 1 + 3 * TICK_DIV, "R5 pause length", last_gap, RESP_LAT + 1 + 3 * TICK_DIV);
        settle();

        // R9: disable while attempt in flight
        cfg_mon_en = 1; cfg_pause = 0;
        write_addr(10'h013, 1);
        wait_for(1, 0, 50);
        cfg_mon_en = 0;
        repeat (100) @(negedge clk);
        chk(start_cnt == 1 && rdy_cnt == 0, "R9 stop after attempt", start_cnt, 1);
        settle();

        // R9: disable during pause
        cfg_mon_en = 1; cfg_pause = 15;
        write_addr(10'h013, 1);
        wait_for(1, 0, 50);
        repeat (RESP_LAT + 10) @(negedge clk);
        cfg_mon_en = 0;
        repeat (150) @(negedge clk);
        chk(start_cnt == 1, "R9 stop in pause", start_cnt, 1);
        settle();

        // R10: rewrite during pause
        cfg_mon_en = 1; cfg_pause = 15;
        write_addr(10'h011, 1);
        wait_for(1, 0, 50);
        repeat (12) @(negedge clk);
        write_addr(10'h033, 1);
        repeat (2) @(negedge clk);
        chk(start_cnt == 2 && last_b0 == 8'h66, "R10 restart in pause", int'(last_b0), 'h66);
        settle();

        // R10 R11: rewrite while attempt in flight, first ACK discarded
        cfg_mon_en = 1; cfg_pause = 0;
        ack_q = '{1, 1};
        write_addr(10'h011, 1);
        wait_for(1, 0, 50);
        write_addr(10'h022, 1);
        wait_for(2, 1, 100);
        chk(start_cnt == 2 && rdy_cnt == 1, "R10 discarded result", start_cnt * 10 + rdy_cnt, 21);
        chk(last_b0 == 8'h44, "R11 new address used", int'(last_b0), 'h44);
        settle();

        summary();
    end
endmodule